// File: doc/BRIEF.md
# Two-Source Prioritized Interrupt Controller

This block decides when a small 8-bit core leaves its program flow to service an interrupt. It watches two sources: a level-sensitive external pin request and a timer/counter overflow event. Each source has its own enable and disable strobe. At each instruction boundary the block looks at the enabled requests. If it is not already servicing an interrupt, it raises a one-cycle take pulse and gives the program-memory address the core must jump to.

The external source always wins a tie and goes to address 3. The timer source goes to address 7. Once an interrupt is taken, a global in-service lock blocks every further take until the core signals a return-from-interrupt. An ordinary subroutine return does not release the lock, and no status word is saved. The timer event is held in a pending flag. That flag clears only when its own vector is taken. The external request is a live level, and the device must drop it before the return.

Top module: `irq2_ctrl`

## Requirements
- R1: After reset both sources are disabled, the pending timer flag is clear, the lock is clear, and `take_o` is 0.
- R2: A take happens only in a cycle with `boundary_i` high. In that cycle `take_o` is 1 for exactly that cycle, with no delay from the inputs, and `vector_o` holds the target address.
- R3: An enabled external request (`ext_req_i` high at a boundary) is taken with `vector_o` = 3.
- R4: An enabled pending timer flag is taken with `vector_o` = 7. A `tmr_evt_i` pulse sets the flag from the next cycle on, even when no boundary is present.
- R5: When both enabled requests are present at one boundary, the external one is taken. The timer flag stays set and is taken at the first boundary after the lock is released.
- R6: After any take, no take occurs until a `reti_i` pulse. A `ret_i` pulse has no effect on the lock. The lock clears in the cycle after `reti_i`.
- R7: The enable strobes `ext_en_i`/`tmr_en_i` set a source's enable and the `ext_dis_i`/`tmr_dis_i` strobes clear it, both from the next cycle. If both strobes are high in the same cycle, disable wins. A disabled source is never taken. A timer event that arrives while the timer source is disabled is still latched, and it is taken once the source is enabled.
- R8: The timer flag is cleared in the cycle after its vector is taken, and only then (or by reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req_i | input | 1 | External pin request, level |
| tmr_evt_i | input | 1 | Timer/counter event pulse |
| ext_en_i | input | 1 | Enable strobe, external source |
| ext_dis_i | input | 1 | Disable strobe, external source |
| tmr_en_i | input | 1 | Enable strobe, timer source |
| tmr_dis_i | input | 1 | Disable strobe, timer source |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ret_i | input | 1 | Ordinary return strobe (does not unlock) |
| boundary_i | input | 1 | Instruction boundary |
| take_o | output | 1 | Interrupt take pulse |
| vector_o | output | 12 | Program-memory vector address |

## Verification
Two kinds of collision need testing. The first is an external request and a pending timer flag arriving at the same boundary. The second is a new timer event landing in the cycle its own vector is taken. The bench forces both by driving the strobes on chosen cycles. It then compares the vector and the flag's later behaviour with a behavioural model on every clock. A timer event arriving during the take must survive the clear, because set has priority. Otherwise it would be lost.

// File: rtl/irq2_pkg.sv
package irq2_pkg;
    parameter int unsigned VEC_W = 12;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_TMR  = 2'd2
    } src_e;

    localparam logic [VEC_W-1:0] VEC_EXT = VEC_W'(3);
    localparam logic [VEC_W-1:0] VEC_TMR = VEC_W'(7);

    typedef struct packed {
        logic ext_en;
        logic tmr_en;
    } en_t;

    function automatic logic [VEC_W-1:0] src_vector(src_e s);
        case (s)
            SRC_EXT: return VEC_EXT;
            SRC_TMR: return VEC_TMR;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/irq2_enables.sv
module irq2_enables
    import irq2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ext_en_i,
    input  logic ext_dis_i,
    input  logic tmr_en_i,
    input  logic tmr_dis_i,
    output en_t  en_o
);
    en_t en_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            if (ext_dis_i)     en_q.ext_en <= 1'b0;
            else if (ext_en_i) en_q.ext_en <= 1'b1;
            if (tmr_dis_i)     en_q.tmr_en <= 1'b0;
            else if (tmr_en_i) en_q.tmr_en <= 1'b1;
        end
    end
    assign en_o = en_q;
endmodule

// File: rtl/irq2_arbiter.sv
module irq2_arbiter
    import irq2_pkg::*;
(
    input  logic boundary_i,
    input  logic locked_i,
    input  en_t  en_i,
    input  logic ext_req_i,
    input  logic tmr_pend_i,
    output src_e win_o
);
    logic ext_ok, tmr_ok;
    assign ext_ok = en_i.ext_en & ext_req_i;
    assign tmr_ok = en_i.tmr_en & tmr_pend_i;

    always_comb begin
        win_o = SRC_NONE;
        if (boundary_i && !locked_i) begin
            if (ext_ok)      win_o = SRC_EXT;
            else if (tmr_ok) win_o = SRC_TMR;
        end
    end
endmodule

// File: rtl/irq2_ctrl.sv
module irq2_ctrl
    import irq2_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_req_i,
    input  logic             tmr_evt_i,
    input  logic             ext_en_i,
    input  logic             ext_dis_i,
    input  logic             tmr_en_i,
    input  logic             tmr_dis_i,
    input  logic             reti_i,
    input  logic             ret_i,
    input  logic             boundary_i,
    output logic             take_o,
    output logic [VEC_W-1:0] vector_o
);
    en_t  en;
    src_e win;
    logic locked_q;
    logic tmr_pend_q;

    irq2_enables u_en (
        .clk(clk), .rst(rst),
        .ext_en_i(ext_en_i), .ext_dis_i(ext_dis_i),
        .tmr_en_i(tmr_en_i), .tmr_dis_i(tmr_dis_i),
        .en_o(en)
    );

    irq2_arbiter u_arb (
        .boundary_i(boundary_i), .locked_i(locked_q), .en_i(en),
        .ext_req_i(ext_req_i), .tmr_pend_i(tmr_pend_q), .win_o(win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q   <= 1'b0;
            tmr_pend_q <= 1'b0;
        end else begin
            if (win != SRC_NONE) locked_q <= 1'b1;
            else if (reti_i)     locked_q <= 1'b0;
            if (tmr_evt_i)             tmr_pend_q <= 1'b1;
            else if (win == SRC_TMR)   tmr_pend_q <= 1'b0;
        end
    end

    assign take_o   = (win != SRC_NONE);
    assign vector_o = src_vector(win);

    logic unused_ret;
    assign unused_ret = ret_i;
endmodule

// File: rtl/irq2_ctrl_chk.sv
module irq2_ctrl_chk
    import irq2_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             boundary_i,
    input logic             reti_i,
    input logic             ext_req_i,
    input logic             take_o,
    input logic [VEC_W-1:0] vector_o,
    input logic             locked_q,
    input logic             tmr_pend_q,
    input logic             tmr_evt_i,
    input en_t              en
);
    assert_take_on_boundary_R2: assert property (@(posedge clk) disable iff (rst)
        take_o |-> boundary_i);
    assert_vector_legal_R3: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (vector_o == VEC_EXT || vector_o == VEC_TMR));
    assert_ext_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (take_o && ext_req_i && en.ext_en) |-> vector_o == VEC_EXT);
    assert_lock_after_take_R6: assert property (@(posedge clk) disable iff (rst)
        take_o |=> locked_q);
    assert_no_take_locked_R6: assert property (@(posedge clk) disable iff (rst)
        locked_q |-> !take_o);
    assert_tmr_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (take_o && vector_o == VEC_TMR && !tmr_evt_i) |=> !tmr_pend_q);
    assert_tmr_held_R8: assert property (@(posedge clk) disable iff (rst)
        (tmr_pend_q && !(take_o && vector_o == VEC_TMR)) |=> tmr_pend_q);
    assert_disabled_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (take_o && vector_o == VEC_TMR) |-> en.tmr_en);
endmodule

bind irq2_ctrl irq2_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .boundary_i(boundary_i), .reti_i(reti_i),
    .ext_req_i(ext_req_i), .take_o(take_o), .vector_o(vector_o),
    .locked_q(locked_q), .tmr_pend_q(tmr_pend_q), .tmr_evt_i(tmr_evt_i),
    .en(en)
);

// File: tb/tb_irq2_ctrl.sv
module tb_irq2_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_req_i = 0, tmr_evt_i = 0, ext_en_i = 0, ext_dis_i = 0;
    logic tmr_en_i = 0, tmr_dis_i = 0, reti_i = 0, ret_i = 0, boundary_i = 0;
    logic take_o;
    logic [11:0] vector_o;

    int checks = 0, fails = 0;
    int cyc = 0;

    // behavioural model state
    bit m_ext_en, m_tmr_en, m_pend, m_lock;
    bit m_take; int m_vec;

    always #5 clk = ~clk;

    irq2_ctrl dut (.*);

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // model combinational prediction
    function automatic void predict();
        m_take = 0; m_vec = 0;
        if (boundary_i && !m_lock) begin
            if (m_ext_en && ext_req_i) begin m_take = 1; m_vec = 3; end
            else if (m_tmr_en && m_pend) begin m_take = 1; m_vec = 7; end
        end
    endfunction

    // compare every cycle just before the edge, then update model
    always @(negedge clk) begin
        if (!rst) begin
            predict();
            check("R2/R3/R4", int'(take_o), int'(m_take));
            if (m_take) check("R3/R4/R5 vector", int'(vector_o), m_vec);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_ext_en = 0; m_tmr_en = 0; m_pend = 0; m_lock = 0;
        end else begin
            predict();
            if (m_take) m_lock = 1; else if (reti_i) m_lock = 0;
            if (tmr_evt_i) m_pend = 1; else if (m_take && m_vec == 7) m_pend = 0;
            if (ext_dis_i) m_ext_en = 0; else if (ext_en_i) m_ext_en = 1;
            if (tmr_dis_i) m_tmr_en = 0; else if (tmr_en_i) m_tmr_en = 1;
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #2;
        ext_en_i = 0; ext_dis_i = 0; tmr_en_i = 0; tmr_dis_i = 0;
        reti_i = 0; ret_i = 0; tmr_evt_i = 0; boundary_i = 0;
    endtask

    // one boundary cycle, sample take at mid-cycle
    task automatic bnd(output bit t, output int v);
        boundary_i = 1; #3;
        t = take_o; v = int'(vector_o);
        step();
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit t; int v;
        step(3);
        rst = 0; #1;
        // R1: reset state, request with nothing enabled is ignored
        ext_req_i = 1; tmr_evt_i = 1; step();
        bnd(t, v); check("R1 no take after reset", t, 0);
        ext_req_i = 0;
        // R7: enable+disable same cycle -> disabled
        ext_en_i = 1; ext_dis_i = 1; step();
        ext_req_i = 1; bnd(t, v); check("R7 disable wins", t, 0);
        // R3: external take
        ext_en_i = 1; step();
        boundary_i = 0; #3; check("R2 no take off boundary", take_o, 0); step();
        bnd(t, v); check("R3 ext take", t, 1); check("R3 vector 3", v, 3);
        ext_req_i = 0;
        // R6: ret does not unlock; timer enabled, pending from before
        tmr_en_i = 1; ret_i = 1; step();
        bnd(t, v); check("R6 ret keeps lock", t, 0);
        reti_i = 1; step();
        bnd(t, v); check("R4 pending tmr taken after reti", t, 1); check("R4 vector 7", v, 7);
        reti_i = 1; step();
        bnd(t, v); check("R8 flag cleared after take", t, 0);
        // R5: simultaneous
        tmr_evt_i = 1; ext_req_i = 1; step();
        bnd(t, v); check("R5 ext wins", v, 3);
        ext_req_i = 0; reti_i = 1; step();
        bnd(t, v); check("R5 loser taken after reti", t, 1); check("R5 vector 7", v, 7);
        // R8: event coincides with own take -> set wins
        reti_i = 1; tmr_evt_i = 1; step();
        tmr_evt_i = 1; reti_i = 1; boundary_i = 1; #3;
        check("R4 take with coincident event", take_o, 1);
        step();
        bnd(t, v); check("R6 locked after take", t, 0);
        reti_i = 1; step();
        bnd(t, v); check("R8 event during take retained", t, 1);
        // R7: disabled timer still latches, taken once enabled
        reti_i = 1; tmr_dis_i = 1; tmr_evt_i = 1; step();
        bnd(t, v); check("R7 disabled tmr ignored", t, 0);
        tmr_en_i = 1; step();
        bnd(t, v); check("R7 latched event taken on enable", v, 7);
        step(3);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule